// File: doc/BRIEF.md
# Decode Stage Controller

This block is the decode step of an in-order front end that feeds an out-of-order core. Each cycle it may receive a fetch group of up to `W` instruction records. Live records go on to rename, packed from slot 0 upward. Records already marked squashed are dropped and counted. A record with no source operands is flagged ready to issue.

The stage also resolves unconditional direct branches by comparing the branch target with the predicted next PC. On a mismatch it redirects fetch to the target and abandons the rest of the group. A record predicted taken that is not a control instruction raises an error and takes the same redirect path.

A stall from rename, execute or commit parks incoming groups in a skid buffer of whole groups. Once the stalls clear, the stage drains that buffer oldest first before it takes new fetch input. A squash from commit, or the reorder buffer reporting that it is squashing, empties the buffer and holds the stage until both indications drop. Event counters record how the stage spends its cycles.

Top module: `dec_stage`

## Requirements
- R1: After reset the controller is idle, every output is 0 and every counter reads 0.
- R2: A record taken for processing in the cycle ending at clock edge k appears on `rn_rec` after edge k, bit for bit. The record layout, LSB first, is: bit0 unconditional, bit1 direct, bit2 control, bit3 predicted taken, bit4 squashed, bits 6:5 source count, bits 22:7 predicted next PC, bits 38:23 branch target, bits 54:39 PC and bits 62:55 sequence number. Slot s occupies bits [63*s +: 63] of `in_rec` and `rn_rec`.
- R3: Forwarded records are compacted into `rn_vld` from slot 0 upward, with no gaps and in program order.
- R4: A record whose squashed bit is set is never forwarded and never triggers a redirect. It adds 1 to `cnt_skip`.
- R5: `rn_rdy` is 1 for a forwarded slot whose source count is 0, and 0 otherwise.
- R6: When any of `stall_rn`, `stall_ex` or `stall_cm` is high, the incoming group is stored rather than forwarded, and `fe_stall` goes high from the next cycle. While the stage is blocked, every further valid group is also stored.
- R7: When the stalls clear, the stage goes through one blocked cycle and then drains one stored group per cycle, oldest first and ahead of any new fetch group. Groups that arrive during the drain are queued behind the stored ones. `fe_stall` stays high until the last stored group is drained.
- R8: `cm_squash` or `cm_robsq` empties the skid buffer and puts the stage into squashing. Nothing is forwarded while either input is high. The stage resumes normal work in the cycle after both inputs are low.
- R9: An unconditional direct record whose target differs from its predicted next PC is still forwarded, but later records in its group are dropped. For one cycle `fe_redir`, `fe_mispred` and `fe_taken` are 1, `fe_pc` carries the target and `fe_seq` carries the record's sequence number. The skid buffer is emptied and `cnt_misp` increments. Conditional branches and correctly predicted branches cause no redirect.
- R10: A record predicted taken but not marked control is forwarded and drops the rest of its group. For one cycle it pulses `err_ctl` and raises the same redirect with `fe_pc` equal to its PC + 4. `cnt_misp` is left unchanged.
- R11: A store into a full skid buffer, with no pop in that cycle, drops the group and pulses `err_ovf` for one cycle.
- R12: `cnt_idle` counts active cycles with no work. `cnt_blk` counts cycles spent blocked, `cnt_unb` draining cycles and `cnt_sq` cycles spent squashing. `cnt_dec` counts forwarded records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | W | Valid mask of the incoming fetch group |
| in_rec | input | W*63 | Incoming records |
| stall_rn | input | 1 | Stall from rename |
| stall_ex | input | 1 | Stall from execute |
| stall_cm | input | 1 | Stall from commit |
| cm_squash | input | 1 | Squash from commit |
| cm_robsq | input | 1 | Reorder buffer is squashing |
| rn_vld | output | W | Packed valid mask to rename |
| rn_rdy | output | W | Ready-to-issue flag per slot |
| rn_rec | output | W*63 | Records to rename |
| fe_stall | output | 1 | Hold request to fetch |
| fe_redir | output | 1 | Redirect pulse to fetch |
| fe_mispred | output | 1 | Redirect caused by a misprediction |
| fe_taken | output | 1 | Redirect path is taken |
| fe_pc | output | 16 | New fetch PC |
| fe_seq | output | 8 | Sequence number of the redirecting record |
| err_ovf | output | 1 | Skid buffer overflow pulse |
| err_ctl | output | 1 | Taken prediction on a non-control record |
| cnt_idle | output | 16 | Idle cycle count |
| cnt_blk | output | 16 | Blocked cycle count |
| cnt_unb | output | 16 | Draining cycle count |
| cnt_sq | output | 16 | Squashing cycle count |
| cnt_misp | output | 16 | Branch mispredicts found at decode |
| cnt_dec | output | 16 | Forwarded record count |
| cnt_skip | output | 16 | Skipped squashed record count |

## Verification
The bench drains a buffer holding two stored groups while a third group arrives mid-drain. A design that let new fetch input overtake stored groups, or dropped `fe_stall` early, would show the groups out of order or the stall low too soon. Mixed groups with squashed records in the middle expose a design that leaves gaps in `rn_vld` or redirects on a squashed mispredicted branch. A mispredicted branch in slot 1 must forward exactly two records; a design that kept going would forward four, and one that flushed the branch itself would forward one. The bench also fills the buffer to one group past its depth, then holds `cm_robsq` after a squash, to catch a silent wrap-around and an early exit from squashing.

// File: rtl/dec_pkg.sv
package dec_pkg;
    localparam int SEQ_W      = 8;
    localparam int PC_W       = 16;
    localparam int SRC_W      = 2;
    localparam int CNT_W      = 16;
    localparam int INSN_BYTES = 4;

    typedef struct packed {
        logic [SEQ_W-1:0] seq;
        logic [PC_W-1:0]  pc;
        logic [PC_W-1:0]  tgt;
        logic [PC_W-1:0]  pnpc;
        logic [SRC_W-1:0] nsrc;
        logic             squashed;
        logic             pred_tk;
        logic             is_ctl;
        logic             is_dir;
        logic             is_unc;
    } rec_t;

    localparam int REC_W = $bits(rec_t);

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RUN  = 3'd1,
        ST_BLK  = 3'd2,
        ST_UNB  = 3'd3,
        ST_SQ   = 3'd4
    } st_e;

    // event counter slots
    localparam int N_CNT  = 7;
    localparam int C_IDLE = 0;
    localparam int C_BLK  = 1;
    localparam int C_UNB  = 2;
    localparam int C_SQ   = 3;
    localparam int C_MISP = 4;
    localparam int C_DEC  = 5;
    localparam int C_SKIP = 6;
endpackage

// File: rtl/dec_skid.sv
module dec_skid
    import dec_pkg::*;
#(
    parameter int W = 4,
    parameter int D = 4
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    input  logic [W-1:0]     din_vld,
    input  rec_t [W-1:0]     din_rec,
    output logic [W-1:0]     head_vld,
    output rec_t [W-1:0]     head_rec,
    output logic             empty,
    output logic             single,
    output logic             full
);
    localparam int AW = (D > 1) ? $clog2(D) : 1;
    localparam int LW = $clog2(D + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [LW-1:0] lvl;
    } ctl_t;

    ctl_t c_q, c_d;
    logic do_push, do_pop;

    logic [W-1:0] mem_vld [D];
    rec_t [W-1:0] mem_rec [D];

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(D - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        do_pop  = pop && (c_q.lvl != '0);
        do_push = push && !flush && ((c_q.lvl != LW'(D)) || do_pop);
        c_d     = c_q;
        if (flush) begin
            c_d = '0;
        end else begin
            if (do_push) c_d.wp = wrap_inc(c_q.wp);
            if (do_pop)  c_d.rp = wrap_inc(c_q.rp);
            c_d.lvl = c_q.lvl + LW'(do_push) - LW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_vld[c_q.wp] <= din_vld;
            mem_rec[c_q.wp] <= din_rec;
        end
    end

    assign head_vld = mem_vld[c_q.rp];
    assign head_rec = mem_rec[c_q.rp];
    assign empty    = (c_q.lvl == '0);
    assign single   = (c_q.lvl == LW'(1));
    assign full     = (c_q.lvl == LW'(D));

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.lvl <= LW'(D)); // R11
    AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R7
endmodule

// File: rtl/dec_group_proc.sv
module dec_group_proc
    import dec_pkg::*;
#(
    parameter  int W  = 4,
    localparam int NW = $clog2(W + 1)
)(
    input  logic [W-1:0]     vld,
    input  rec_t [W-1:0]     rec,
    output logic [W-1:0]     fwd_vld,
    output logic [W-1:0]     fwd_rdy,
    output rec_t [W-1:0]     fwd_rec,
    output logic [NW-1:0]    n_dec,
    output logic [NW-1:0]    n_skip,
    output logic             redir,
    output logic             ctl_err,
    output logic             br_misp,
    output logic [PC_W-1:0]  redir_pc,
    output logic [SEQ_W-1:0] redir_seq
);
    localparam int IW = (W > 1) ? $clog2(W) : 1;

    always_comb begin
        logic          halt;
        logic [IW-1:0] j;
        fwd_vld   = '0;
        fwd_rdy   = '0;
        fwd_rec   = '0;
        n_dec     = '0;
        n_skip    = '0;
        redir     = 1'b0;
        ctl_err   = 1'b0;
        br_misp   = 1'b0;
        redir_pc  = '0;
        redir_seq = '0;
        halt      = 1'b0;
        j         = '0;
        for (int i = 0; i < W; i++) begin
            if (vld[i] && !halt) begin
                if (rec[i].squashed) begin
                    n_skip = n_skip + NW'(1);
                end else begin
                    fwd_vld[j] = 1'b1;
                    fwd_rdy[j] = (rec[i].nsrc == '0);
                    fwd_rec[j] = rec[i];
                    j          = j + IW'(1);
                    n_dec      = n_dec + NW'(1);
                    if (rec[i].pred_tk && !rec[i].is_ctl) begin
                        redir     = 1'b1;
                        ctl_err   = 1'b1;
                        redir_pc  = rec[i].pc + PC_W'(INSN_BYTES);
                        redir_seq = rec[i].seq;
                        halt      = 1'b1;
                    end else if (rec[i].is_dir && rec[i].is_unc &&
                                 (rec[i].tgt != rec[i].pnpc)) begin
                        redir     = 1'b1;
                        br_misp   = 1'b1;
                        redir_pc  = rec[i].tgt;
                        redir_seq = rec[i].seq;
                        halt      = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/dec_evt_cnt.sv
module dec_evt_cnt
    import dec_pkg::*;
#(
    parameter int N  = 7,
    parameter int AW = 3
)(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N-1:0][AW-1:0]      amt,
    output logic [N-1:0][CNT_W-1:0]   cnt
);
    logic [N-1:0][CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        for (int k = 0; k < N; k++) begin
            cnt_d[k] = cnt_q[k] + CNT_W'(amt[k]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/dec_stage.sv
module dec_stage
    import dec_pkg::*;
#(
    parameter int W = 4,
    parameter int D = 4
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [W-1:0]         in_vld,
    input  logic [W*REC_W-1:0]   in_rec,
    input  logic                 stall_rn,
    input  logic                 stall_ex,
    input  logic                 stall_cm,
    input  logic                 cm_squash,
    input  logic                 cm_robsq,
    output logic [W-1:0]         rn_vld,
    output logic [W-1:0]         rn_rdy,
    output logic [W*REC_W-1:0]   rn_rec,
    output logic                 fe_stall,
    output logic                 fe_redir,
    output logic                 fe_mispred,
    output logic                 fe_taken,
    output logic [PC_W-1:0]      fe_pc,
    output logic [SEQ_W-1:0]     fe_seq,
    output logic                 err_ovf,
    output logic                 err_ctl,
    output logic [CNT_W-1:0]     cnt_idle,
    output logic [CNT_W-1:0]     cnt_blk,
    output logic [CNT_W-1:0]     cnt_unb,
    output logic [CNT_W-1:0]     cnt_sq,
    output logic [CNT_W-1:0]     cnt_misp,
    output logic [CNT_W-1:0]     cnt_dec,
    output logic [CNT_W-1:0]     cnt_skip
);
    localparam int NW = $clog2(W + 1);

    typedef struct packed {
        st_e              st;
        logic [W-1:0]     rn_vld;
        logic [W-1:0]     rn_rdy;
        rec_t [W-1:0]     rn_rec;
        logic             fe_stall;
        logic             fe_redir;
        logic             fe_mispred;
        logic             fe_taken;
        logic [PC_W-1:0]  fe_pc;
        logic [SEQ_W-1:0] fe_seq;
        logic             err_ovf;
        logic             err_ctl;
    } reg_t;

    reg_t r_q, r_d;

    rec_t [W-1:0] in_r;
    logic         stall_any, sq_in, use_head;
    logic         push, pop, flush, do_proc;

    logic [W-1:0] sk_vld;
    rec_t [W-1:0] sk_rec;
    logic         sk_empty, sk_single, sk_full;

    logic [W-1:0] p_in_vld;
    rec_t [W-1:0] p_in_rec;
    logic [W-1:0] p_vld, p_rdy;
    rec_t [W-1:0] p_rec;
    logic [NW-1:0] p_ndec, p_nskip;
    logic         p_redir, p_ctl, p_misp;
    logic [PC_W-1:0]  p_pc;
    logic [SEQ_W-1:0] p_seq;

    logic [N_CNT-1:0][NW-1:0]    amt;
    logic [N_CNT-1:0][CNT_W-1:0] cnt;

    assign in_r      = in_rec;
    assign stall_any = stall_rn | stall_ex | stall_cm;
    assign sq_in     = cm_squash | cm_robsq;
    assign use_head  = (r_q.st == ST_UNB) && !sk_empty;
    assign p_in_vld  = use_head ? sk_vld : in_vld;
    assign p_in_rec  = use_head ? sk_rec : in_r;

    dec_skid #(.W(W), .D(D)) u_skid (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop),
        .flush    (flush),
        .din_vld  (in_vld),
        .din_rec  (in_r),
        .head_vld (sk_vld),
        .head_rec (sk_rec),
        .empty    (sk_empty),
        .single   (sk_single),
        .full     (sk_full)
    );

    dec_group_proc #(.W(W)) u_proc (
        .vld       (p_in_vld),
        .rec       (p_in_rec),
        .fwd_vld   (p_vld),
        .fwd_rdy   (p_rdy),
        .fwd_rec   (p_rec),
        .n_dec     (p_ndec),
        .n_skip    (p_nskip),
        .redir     (p_redir),
        .ctl_err   (p_ctl),
        .br_misp   (p_misp),
        .redir_pc  (p_pc),
        .redir_seq (p_seq)
    );

    dec_evt_cnt #(.N(N_CNT), .AW(NW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .amt   (amt),
        .cnt   (cnt)
    );

    always_comb begin
        r_d     = '0;
        r_d.st  = r_q.st;
        push    = 1'b0;
        pop     = 1'b0;
        flush   = 1'b0;
        do_proc = 1'b0;
        amt     = '0;
        unique case (r_q.st)
            ST_IDLE, ST_RUN, ST_UNB: begin
                if (sq_in) begin
                    flush  = 1'b1;
                    r_d.st = ST_SQ;
                end else if (stall_any) begin
                    push   = |in_vld;
                    r_d.st = ST_BLK;
                end else if (r_q.st == ST_UNB) begin
                    amt[C_UNB] = NW'(1);
                    do_proc    = 1'b1;
                    if (!sk_empty) begin
                        pop  = 1'b1;
                        push = |in_vld;
                    end
                    r_d.st = (!sk_empty && (!sk_single || push)) ? ST_UNB : ST_RUN;
                end else if (|in_vld) begin
                    do_proc = 1'b1;
                    r_d.st  = ST_RUN;
                end else begin
                    amt[C_IDLE] = NW'(1);
                end
            end
            ST_BLK: begin
                amt[C_BLK] = NW'(1);
                push       = |in_vld;
                if (sq_in) begin
                    flush  = 1'b1;
                    r_d.st = ST_SQ;
                end else if (!stall_any) begin
                    r_d.st = ST_UNB;
                end
            end
            ST_SQ: begin
                amt[C_SQ] = NW'(1);
                if (!sq_in) r_d.st = ST_RUN;
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (do_proc) begin
            r_d.rn_vld   = p_vld;
            r_d.rn_rdy   = p_rdy;
            r_d.rn_rec   = p_rec;
            amt[C_DEC]   = p_ndec;
            amt[C_SKIP]  = p_nskip;
            if (p_redir) begin
                flush          = 1'b1;
                r_d.st         = ST_SQ;
                r_d.fe_redir   = 1'b1;
                r_d.fe_mispred = 1'b1;
                r_d.fe_taken   = 1'b1;
                r_d.fe_pc      = p_pc;
                r_d.fe_seq     = p_seq;
                r_d.err_ctl    = p_ctl;
                amt[C_MISP]    = NW'(p_misp);
            end
        end

        r_d.err_ovf  = push && !flush && sk_full && !pop;
        r_d.fe_stall = (r_d.st == ST_BLK) || (r_d.st == ST_UNB);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rn_vld     = r_q.rn_vld;
    assign rn_rdy     = r_q.rn_rdy;
    assign rn_rec     = r_q.rn_rec;
    assign fe_stall   = r_q.fe_stall;
    assign fe_redir   = r_q.fe_redir;
    assign fe_mispred = r_q.fe_mispred;
    assign fe_taken   = r_q.fe_taken;
    assign fe_pc      = r_q.fe_pc;
    assign fe_seq     = r_q.fe_seq;
    assign err_ovf    = r_q.err_ovf;
    assign err_ctl    = r_q.err_ctl;
    assign cnt_idle   = cnt[C_IDLE];
    assign cnt_blk    = cnt[C_BLK];
    assign cnt_unb    = cnt[C_UNB];
    assign cnt_sq     = cnt[C_SQ];
    assign cnt_misp   = cnt[C_MISP];
    assign cnt_dec    = cnt[C_DEC];
    assign cnt_skip   = cnt[C_SKIP];

    AST_RN_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((rn_vld & (rn_vld + W'(1))) == '0)); // R3
    AST_SQ_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_squash || cm_robsq) |=> (rn_vld == '0)); // R8
    AST_REDIR_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        fe_redir |=> !fe_redir); // R9
    AST_REDIR_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        fe_redir |-> !fe_stall); // R9
    AST_STALL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_any && !sq_in && r_q.st != ST_SQ) |=> fe_stall); // R6
endmodule

// File: tb/test_dec_stage.sv
module test_dec_stage;
    import dec_pkg::*;

    localparam int  W     = 4;
    localparam int  D     = 4;
    localparam time CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] in_vld;
    rec_t [W-1:0] in_r;
    logic stall_rn, stall_ex, stall_cm, cm_squash, cm_robsq;
    logic [W-1:0] rn_vld, rn_rdy;
    logic [W*REC_W-1:0] rn_rec;
    rec_t [W-1:0] rn_r;
    logic fe_stall, fe_redir, fe_mispred, fe_taken, err_ovf, err_ctl;
    logic [PC_W-1:0] fe_pc;
    logic [SEQ_W-1:0] fe_seq;
    logic [CNT_W-1:0] cnt_idle, cnt_blk, cnt_unb, cnt_sq, cnt_misp, cnt_dec, cnt_skip;

    int n_chk = 0;
    int n_bad = 0;

    assign rn_r = rn_rec;

    dec_stage #(.W(W), .D(D)) i_dec_stage (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_rec(in_r),
        .stall_rn(stall_rn), .stall_ex(stall_ex), .stall_cm(stall_cm),
        .cm_squash(cm_squash), .cm_robsq(cm_robsq),
        .rn_vld(rn_vld), .rn_rdy(rn_rdy), .rn_rec(rn_rec),
        .fe_stall(fe_stall), .fe_redir(fe_redir), .fe_mispred(fe_mispred),
        .fe_taken(fe_taken), .fe_pc(fe_pc), .fe_seq(fe_seq),
        .err_ovf(err_ovf), .err_ctl(err_ctl),
        .cnt_idle(cnt_idle), .cnt_blk(cnt_blk), .cnt_unb(cnt_unb), .cnt_sq(cnt_sq),
        .cnt_misp(cnt_misp), .cnt_dec(cnt_dec), .cnt_skip(cnt_skip)
    );

    always #(CLK_P / 2) clk = ~clk;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic rec_t mk(input int seq, input int pc, input int tgt, input int pnpc,
                                input int nsrc, input logic sq, input logic pt,
                                input logic ctl, input logic dir, input logic unc);
        rec_t r;
        r.seq = seq[SEQ_W-1:0];
        r.pc = pc[PC_W-1:0];
        r.tgt = tgt[PC_W-1:0];
        r.pnpc = pnpc[PC_W-1:0];
        r.nsrc = nsrc[SRC_W-1:0];
        r.squashed = sq;
        r.pred_tk = pt;
        r.is_ctl = ctl;
        r.is_dir = dir;
        r.is_unc = unc;
        return r;
    endfunction

    function automatic rec_t plain(input int seq, input int nsrc);
        return mk(seq, 16'h100 + seq * 4, 0, 0, nsrc, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic quiet();
        in_vld = '0;
        in_r = '0;
    endtask

    task automatic t_reset();
        chk("R1", "rn_vld", rn_vld, 0);
        chk("R1", "fe_stall", fe_stall, 0);
        chk("R1", "fe_redir", fe_redir, 0);
        chk("R1", "errors", {err_ovf, err_ctl}, 0);
        chk("R1", "counters", cnt_dec + cnt_skip + cnt_blk + cnt_unb + cnt_sq + cnt_misp, 0);
        tick();
        chk("R12", "idle count", cnt_idle, 1);
    endtask

    task automatic t_forward();
        rec_t [W-1:0] g;
        int d0 = cnt_dec;
        for (int i = 0; i < W; i++) g[i] = plain(i + 1, (i == 1) ? 0 : 2);
        in_vld = '1; in_r = g;
        tick();
        quiet();
        chk("R2", "vld full group", rn_vld, 4'b1111);
        for (int i = 0; i < W; i++) chk("R2", "record passthrough", longint'(rn_r[i]), longint'(g[i]));
        chk("R5", "ready mask", rn_rdy, 4'b0010);
        chk("R12", "decoded count", cnt_dec - d0, 4);
        tick();
        chk("R2", "no group no output", rn_vld, 0);
    endtask

    task automatic t_skip();
        rec_t [W-1:0] g;
        int s0 = cnt_skip;
        g[0] = plain(8'h40, 1);
        g[1] = mk(8'h41, 16'h104, 16'h900, 16'h108, 1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        g[2] = mk(8'h42, 16'h108, 0, 0, 1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        g[3] = plain(8'h43, 0);
        in_vld = '1; in_r = g;
        tick();
        quiet();
        chk("R3", "compacted mask", rn_vld, 4'b0011);
        chk("R3", "slot0", longint'(rn_r[0]), longint'(g[0]));
        chk("R3", "slot1 holds last", longint'(rn_r[1]), longint'(g[3]));
        chk("R5", "ready after compaction", rn_rdy, 4'b0010);
        chk("R4", "skip count", cnt_skip - s0, 2);
        chk("R4", "no redirect on squashed branch", fe_redir, 0);
    endtask

    task automatic t_block_drain();
        rec_t [W-1:0] ga, gb, gc;
        int b0 = cnt_blk;
        int u0 = cnt_unb;
        ga = '0; gb = '0; gc = '0;
        ga[0] = plain(8'h10, 1); ga[1] = plain(8'h11, 1);
        for (int i = 0; i < W; i++) gb[i] = plain(8'h20 + i, 1);
        gc[0] = plain(8'h30, 1);
        stall_rn = 1'b1; in_vld = 4'b0011; in_r = ga;
        tick();
        chk("R6", "stall raised", fe_stall, 1);
        chk("R6", "held not forwarded", rn_vld, 0);
        in_vld = 4'b1111; in_r = gb;
        tick();
        chk("R6", "still stalled", fe_stall, 1);
        chk("R6", "second held", rn_vld, 0);
        stall_rn = 1'b0; quiet();
        tick();
        chk("R7", "stall kept on transition", fe_stall, 1);
        chk("R7", "nothing yet", rn_vld, 0);
        in_vld = 4'b0001; in_r = gc;
        tick();
        quiet();
        chk("R7", "first group out", rn_vld, 4'b0011);
        chk("R7", "first group seq", rn_r[0].seq, 8'h10);
        chk("R7", "stall during drain", fe_stall, 1);
        tick();
        chk("R7", "second group out", rn_vld, 4'b1111);
        chk("R7", "second group seq", rn_r[3].seq, 8'h23);
        chk("R7", "stall during drain 2", fe_stall, 1);
        tick();
        chk("R7", "late group out", rn_vld, 4'b0001);
        chk("R7", "late group seq", rn_r[0].seq, 8'h30);
        chk("R7", "stall released", fe_stall, 0);
        chk("R12", "blocked cycles", cnt_blk - b0, 2);
        chk("R12", "draining cycles", cnt_unb - u0, 3);
    endtask

    task automatic t_overflow_squash();
        rec_t [W-1:0] g;
        int q0;
        stall_ex = 1'b1;
        for (int k = 0; k < D + 1; k++) begin
            g = '0;
            g[0] = plain(8'h50 + k, 1);
            in_vld = 4'b0001; in_r = g;
            tick();
            if (k == D - 1) chk("R11", "no overflow at depth", err_ovf, 0);
        end
        chk("R11", "overflow pulse", err_ovf, 1);
        quiet(); cm_squash = 1'b1;
        tick();
        chk("R11", "overflow one cycle", err_ovf, 0);
        chk("R8", "stall dropped on squash", fe_stall, 0);
        q0 = cnt_sq;
        cm_squash = 1'b0; stall_ex = 1'b0; cm_robsq = 1'b1;
        g = '0; g[0] = plain(8'h60, 1);
        in_vld = 4'b0001; in_r = g;
        tick();
        chk("R8", "nothing forwarded while squashing", rn_vld, 0);
        cm_robsq = 1'b0; quiet();
        tick();
        chk("R8", "no drain after flush", rn_vld, 0);
        chk("R8", "no stall after flush", fe_stall, 0);
        chk("R12", "squash cycles", cnt_sq - q0, 2);
        g = '0; g[0] = plain(8'h61, 1);
        in_vld = 4'b0001; in_r = g;
        tick();
        quiet();
        chk("R8", "resumed with new group", rn_r[0].seq, 8'h61);
        chk("R8", "resumed mask", rn_vld, 4'b0001);
        tick();
        chk("R8", "buffer empty, no stale groups", rn_vld, 0);
    endtask

    task automatic t_mispredict();
        rec_t [W-1:0] g;
        int m0 = cnt_misp;
        int d0 = cnt_dec;
        g[0] = plain(8'h70, 1);
        g[1] = mk(8'h71, 16'h104, 16'h200, 16'h108, 1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        g[2] = plain(8'h72, 1);
        g[3] = plain(8'h73, 1);
        in_vld = '1; in_r = g;
        tick();
        quiet();
        chk("R9", "group cut after branch", rn_vld, 4'b0011);
        chk("R9", "branch forwarded", rn_r[1].seq, 8'h71);
        chk("R9", "redirect flags", {fe_redir, fe_mispred, fe_taken}, 3'b111);
        chk("R9", "redirect pc", fe_pc, 16'h200);
        chk("R9", "redirect seq", fe_seq, 8'h71);
        chk("R9", "mispredict count", cnt_misp - m0, 1);
        chk("R12", "decoded incl branch", cnt_dec - d0, 2);
        chk("R10", "no ctl error on branch", err_ctl, 0);
        tick();
        chk("R9", "redirect one cycle", fe_redir, 0);
        g = '0;
        g[0] = mk(8'h74, 16'h200, 16'h300, 16'h300, 1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        g[1] = mk(8'h75, 16'h300, 16'h400, 16'h304, 1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        g[2] = plain(8'h76, 1);
        in_vld = 4'b0111; in_r = g;
        tick();
        quiet();
        chk("R9", "no redirect when correct or conditional", fe_redir, 0);
        chk("R9", "all forwarded", rn_vld, 4'b0111);
        chk("R9", "count unchanged", cnt_misp - m0, 1);
    endtask

    task automatic t_ctl_err();
        rec_t [W-1:0] g;
        int m0 = cnt_misp;
        g = '0;
        g[0] = mk(8'h80, 16'h300, 0, 16'h500, 0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        g[1] = plain(8'h81, 1);
        in_vld = 4'b0011; in_r = g;
        tick();
        quiet();
        chk("R10", "error pulse", err_ctl, 1);
        chk("R10", "redirect", {fe_redir, fe_mispred, fe_taken}, 3'b111);
        chk("R10", "fall-through pc", fe_pc, 16'h304);
        chk("R10", "seq", fe_seq, 8'h80);
        chk("R10", "rest dropped", rn_vld, 4'b0001);
        chk("R10", "ready flag", rn_rdy, 4'b0001);
        chk("R10", "branch count untouched", cnt_misp - m0, 0);
        tick();
        chk("R10", "error one cycle", err_ctl, 0);
        tick();
    endtask

    initial begin
        quiet();
        stall_rn = 0; stall_ex = 0; stall_cm = 0; cm_squash = 0; cm_robsq = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_forward();
        t_skip();
        t_block_drain();
        t_overflow_squash();
        t_mispredict();
        t_ctl_err();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 5000);
        n_chk++;
        n_bad++;
        $display("FAIL R1 watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule